// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a three-wire serial EEPROM link, with chip select, serial clock and data in, and a data-out pin that the block either drives or releases. It holds a 256-word by 16-bit array in flip-flops. It decodes two commands from the serial stream: a sequential read and a timed write. The block runs entirely on a system clock `clk`. It finds the rising edges of the serial clock `sk` by sampling it synchronously, and it takes a `di` bit on each such edge. The tri-state output is split into a data line `dout` and an enable line `dout_en`, and the pad level joins the two.

The command decoder is a state machine. The states are:
- HUNT: search for the start bit.
- OPCODE: take two opcode bits.
- ADDR: take eight address bits, MSB first.
- WDATA: take sixteen data bits.
- WHOLD: all data is in; wait for chip select to fall.
- RDATA: shift out read data.
- IGNORE: an unknown opcode was seen; wait for chip select low.
- BUSY: the internal write is running.
- STATUS: the write has finished and "ready" is shown.

The transitions are:
- HUNT to OPCODE on a 1.
- OPCODE to ADDR or IGNORE.
- ADDR to RDATA for a read, or to WDATA for a write.
- WDATA to WHOLD after the last data bit.
- WHOLD to BUSY when chip select falls.
- BUSY to STATUS when the write timer expires.
- Any shifting, read, ignore or status state to HUNT when chip select is low.

A read outputs a zero dummy bit, then whole words. It moves to the next address for as long as the serial clock keeps running. A write commits its word at the end of a timer whose length is a parameter. While the timer runs, the block shows busy on the data pin if chip select is high.

Top module: `tw_eeprom`

## Requirements
- R1: With `cs` high, `di` is sampled on each `sk` rising edge. Any number of leading 0 bits are skipped. The first 1 is taken as the start bit, and decoding begins with the next bit.
- R2: The two bits after the start bit are the opcode: 2'b10 is a read and 2'b01 is a write. Any other code is ignored: `dout_en` stays 0 until `cs` goes low.
- R3: A read takes an 8-bit address, MSB first. On the edge that captures the last address bit, `dout_en`=1 and `dout`=0 (dummy bit). Each later `sk` edge presents the next bit of the addressed word, D15 first and D0 last.
- R4: While `cs` stays high after D0, further `sk` edges output the word at the next address with no dummy bit. The address wraps from 0xFF to 0x00.
- R5: A write takes an 8-bit address and then 16 data bits, both MSB first. The write starts only when `cs` falls after D0 has been captured. If `cs` falls earlier, the command is dropped and memory is unchanged.
- R6: The internal write lasts WRITE_CYCLES clock cycles, and the new word is stored when it ends. If `cs` is high during the write, `dout_en`=1 with `dout`=0 (busy). After the write ends, `dout`=1 (ready) until `cs` goes low.
- R7: While a write is in progress, serial input is ignored. No command is started or executed.
- R8: `dout_en` is 0 whenever `cs` is low. It is also 0 in every state other than read output, busy and ready.
- R9: After reset, `dout_en`=0 and every memory word reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, edges detected on `clk` |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out level |
| dout_en | output | 1 | Data-out drive enable (0 means high impedance) |

## Verification
The bench aims at four corner cases:
- Leading zeros before the start bit. A decoder that took the first bit after chip select as the start would read the wrong opcode.
- Auto-increment across 0xFF. A design that failed to wrap, or repeated the dummy bit between words, would slip every later bit by one.
- A write cut off before D0. A model that committed on chip-select fall regardless of the bit count would corrupt the word.
- A complete command clocked in while busy. A design that did not lock out input would either drive read data instead of the busy level or overwrite memory.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_WHOLD,
        ST_RDATA,
        ST_IGNORE,
        ST_BUSY,
        ST_STATUS
    } state_t;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/tw_sk_edge.sv
module tw_sk_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic rise
);

    logic sk_s;
    logic sk_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign sk_s = sk;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain[0] <= sk;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end
            assign sk_s = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_s;
    end

    assign rise = sk_s & ~sk_q;

    // R1: one sampling pulse per serial clock edge
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             remain <= '0;
        else if (start)         remain <= CW'(CYCLES);
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
    assign done = (remain == CW'(1));

    // R6: the count never exceeds the programmed write time
    a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= CW'(CYCLES));

    // R6: after the final cycle the timer goes idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 16,
    parameter int WRITE_CYCLES = 500000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_en
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    state_t              state;
    logic [CNT_W-1:0]    cnt;
    logic                op_hi;
    logic                is_rd;
    logic [ADDR_W-1:0]   addr;
    logic [ADDR_W-1:0]   addr_nx;
    logic [ADDR_W-1:0]   addr_in;
    logic [DATA_W-1:0]   sh;
    logic                dout_r;
    logic [DATA_W-1:0]   mem [DEPTH];

    logic sk_rise;
    logic wt_start;
    logic wt_busy;
    logic wt_done;

    tw_sk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sk    (sk),
        .rise  (sk_rise)
    );

    tw_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wt_start),
        .busy  (wt_busy),
        .done  (wt_done)
    );

    assign addr_nx  = addr + ADDR_W'(1);
    assign addr_in  = {addr[ADDR_W-2:0], di};
    assign wt_start = (state == ST_WHOLD) && !cs;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            op_hi  <= 1'b0;
            is_rd  <= 1'b0;
            addr   <= '0;
            sh     <= '0;
            dout_r <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (cs && sk_rise && di) begin
                        state <= ST_OPCODE;
                        cnt   <= '0;
                    end
                end
                ST_OPCODE: begin
                    if (!cs) begin
                        state <= ST_HUNT;
                    end else if (sk_rise) begin
                        if (cnt == '0) begin
                            op_hi <= di;
                            cnt   <= cnt + 1'b1;
                        end else begin
                            cnt <= '0;
                            if ({op_hi, di} == OP_READ) begin
                                is_rd <= 1'b1;
                                state <= ST_ADDR;
                            end else if ({op_hi, di} == OP_WRITE) begin
                                is_rd <= 1'b0;
                                state <= ST_ADDR;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ADDR: begin
                    if (!cs) begin
                        state <= ST_HUNT;
                    end else if (sk_rise) begin
                        addr <= addr_in;
                        if (cnt == ADDR_LAST) begin
                            cnt <= '0;
                            if (is_rd) begin
                                sh     <= mem[addr_in];
                                dout_r <= 1'b0;
                                state  <= ST_RDATA;
                            end else begin
                                state  <= ST_WDATA;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (!cs) begin
                        state <= ST_HUNT;
                    end else if (sk_rise) begin
                        sh <= {sh[DATA_W-2:0], di};
                        if (cnt == DATA_LAST) begin
                            cnt   <= '0;
                            state <= ST_WHOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WHOLD: begin
                    if (!cs) state <= ST_BUSY;
                end
                ST_RDATA: begin
                    if (!cs) begin
                        state <= ST_HUNT;
                    end else if (sk_rise) begin
                        dout_r <= sh[DATA_W-1];
                        if (cnt == DATA_LAST) begin
                            cnt  <= '0;
                            addr <= addr_nx;
                            sh   <= mem[addr_nx];
                        end else begin
                            cnt <= cnt + 1'b1;
                            sh  <= {sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_IGNORE: begin
                    if (!cs) state <= ST_HUNT;
                end
                ST_BUSY: begin
                    if (wt_done) begin
                        mem[addr] <= sh;
                        state     <= ST_STATUS;
                    end
                end
                ST_STATUS: begin
                    if (!cs) state <= ST_HUNT;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // output decode
    always_comb begin
        dout_en = 1'b0;
        dout    = 1'b0;
        unique case (state)
            ST_RDATA: begin
                dout_en = cs;
                dout    = dout_r;
            end
            ST_BUSY: begin
                dout_en = cs;
                dout    = 1'b0;
            end
            ST_STATUS: begin
                dout_en = cs;
                dout    = 1'b1;
            end
            default: begin
                dout_en = 1'b0;
                dout    = 1'b0;
            end
        endcase
    end

    // R8: pin released whenever chip select is low
    a_r8_release_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout_en);

    // R6: busy level is low while the timer runs
    a_r6_busy_level: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_busy && dout_en) |-> !dout);

    // R7: nothing leaves the busy state before the timer expires
    a_r7_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !wt_done) |=> (state == ST_BUSY));

    // R5: timer only launched from a completed write frame
    a_r5_start_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wt_busy) |-> ($past(state) == ST_WHOLD));

    // R5: chip select low aborts a partial frame
    a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && (state == ST_OPCODE || state == ST_ADDR || state == ST_WDATA
                 || state == ST_RDATA)) |=> (state == ST_HUNT));

    // R4: word boundary advances the address by one, modulo the depth
    a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && cs && sk_rise && cnt == DATA_LAST)
            |=> (addr == $past(addr) + ADDR_W'(1)));

endmodule

// File: tb/test_tw_eeprom.sv
module test_tw_eeprom;

    localparam int WC = 400;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic cs    = 1'b0;
    logic sk    = 1'b0;
    logic di    = 1'b0;
    logic dout;
    logic dout_en;

    always #2 clk = ~clk;

    tw_eeprom #(.WRITE_CYCLES(WC)) i_tw_eeprom (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .dout    (dout),
        .dout_en (dout_en)
    );

    int    compared = 0;
    int    mism     = 0;
    int    hold     = 4;
    int    cyc      = 0;
    bit    running  = 1'b1;
    logic  exp_en   = 1'b0;
    logic  exp_do   = 1'b0;
    string req      = "R9";
    logic [15:0] mm [256];

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock comparison against the behavioural expectation
    always @(posedge clk) begin
        #1;
        if (rst_n && running) begin
            if (hold > 0) begin
                hold--;
            end else begin
                compared++;
                if (dout_en !== exp_en || (exp_en && dout !== exp_do)) begin
                    mism++;
                    $display("FAIL %s: dout_en=%b dout=%b expected dout_en=%b dout=%b",
                             req, dout_en, dout, exp_en, exp_do);
                end
            end
        end
    end

    task automatic set_exp(input logic en, input logic d);
        exp_en = en;
        exp_do = d;
        hold   = 3;
    endtask

    task automatic bit_clk(input logic b);
        @(negedge clk);
        di   = b;
        sk   = 1'b1;
        hold = 3;
        repeat (4) @(negedge clk);
        sk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_drive(input logic v, input logic en, input logic d);
        @(negedge clk);
        cs     = v;
        exp_en = en;
        exp_do = d;
        hold   = 3;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_clk(v[i]);
    endtask

    task automatic write_frame(input int lead, input logic [7:0] a,
                               input logic [15:0] d, input int nbits);
        req = "R1";
        cs_drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < lead; i++) bit_clk(1'b0);
        bit_clk(1'b1);
        req = "R5";
        send_bits(32'b01, 2);
        send_bits({24'd0, a}, 8);
        for (int i = 15; i > 15 - nbits; i--) bit_clk(d[i]);
    endtask

    task automatic write_commit(input logic [7:0] a, input logic [15:0] d,
                                input bit intrude);
        int t0;
        req = "R5";
        cs_drive(1'b0, 1'b0, 1'b0);
        t0 = cyc;
        repeat (2) @(negedge clk);
        req = "R6";
        cs_drive(1'b1, 1'b1, 1'b0);
        if (intrude) begin
            // R7: a full read and a full write frame while busy
            req = "R7";
            send_bits({21'd0, 1'b1, 2'b10, 8'h12}, 11);
            send_bits({21'd0, 1'b1, 2'b01, 8'h12}, 11);
            send_bits(32'h0000FFFF, 16);
        end
        while (cyc < t0 + WC - 8) @(negedge clk);
        req    = "R6";
        hold   = 20;
        exp_do = 1'b1;
        repeat (24) @(negedge clk);
        mm[a] = d;
        cs_drive(1'b0, 1'b0, 1'b0);
    endtask

    task automatic read_seq(input int lead, input logic [7:0] a, input int nw);
        logic [7:0] p;
        req = "R1";
        cs_drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < lead; i++) bit_clk(1'b0);
        bit_clk(1'b1);
        req = "R3";
        send_bits(32'b10, 2);
        for (int i = 7; i >= 1; i--) bit_clk(a[i]);
        set_exp(1'b1, 1'b0);
        bit_clk(a[0]);
        p = a;
        for (int w = 0; w < nw; w++) begin
            req = (w == 0) ? "R3" : "R4";
            for (int b = 15; b >= 0; b--) begin
                set_exp(1'b1, mm[p][b]);
                bit_clk(1'b0);
            end
            p = p + 8'd1;
        end
        req = "R8";
        cs_drive(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mism++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mm[i] = 16'h0000;
        repeat (3) @(negedge clk);
        compared++;
        if (dout_en !== 1'b0) begin
            mism++;
            $display("FAIL R9: dout_en=%b in reset, expected 0", dout_en);
        end
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1 leading zeros, R5/R6 normal write with status
        write_frame(3, 8'h12, 16'hA5C3, 16);
        write_commit(8'h12, 16'hA5C3, 1'b0);
        write_frame(0, 8'hFF, 16'h1234, 16);
        write_commit(8'hFF, 16'h1234, 1'b0);
        write_frame(5, 8'h00, 16'hBEEF, 16);
        write_commit(8'h00, 16'hBEEF, 1'b0);

        // R3 dummy bit and word, R4 step into a reset-state word
        read_seq(2, 8'h12, 2);
        // R4 wrap from 0xFF to 0x00
        read_seq(0, 8'hFF, 3);

        // R5 frame cut before D0: no write
        write_frame(1, 8'h40, 16'h7777, 10);
        req = "R5";
        cs_drive(1'b0, 1'b0, 1'b0);
        read_seq(0, 8'h40, 1);

        // R2 unknown opcode 11 keeps the pin released
        req = "R2";
        cs_drive(1'b1, 1'b0, 1'b0);
        send_bits(32'b111, 3);
        send_bits(32'hAA, 8);
        send_bits(32'h5A5A, 16);
        cs_drive(1'b0, 1'b0, 1'b0);

        // R9 untouched word still zero
        read_seq(4, 8'h55, 1);

        // R7 commands during busy are ignored
        write_frame(0, 8'h20, 16'h0F0F, 16);
        write_commit(8'h20, 16'h0F0F, 1'b1);
        read_seq(0, 8'h12, 1);
        read_seq(1, 8'h20, 1);

        repeat (10) @(negedge clk);
        running = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

endmodule